// File: doc/BRIEF.md
# DRAM Strobe Cycle Decoder

This block sits on the device side of an asynchronous multiplexed-address DRAM interface. It samples the active-low row strobe, column strobe and write enable, the shared address bus and the data-in bit with its own clock. From the order in which those strobes change, it classifies each access. A row-strobe period can be a refresh where the column strobe led the row strobe, a refresh that uses only the row strobe, or one or more column accesses. Each column access is a read, an early write or a late (read-modify-write) write.

Every classified access produces a one-clock event carrying a kind code and the captured row, column and data bit, so the block can serve as a bus monitor. It also keeps a small bit array that is written by write accesses and read by read accesses. This lets it act as the front end of a compact memory model, with a data-out bit and an output-enable that behave like the device output.

All strobes, the address and the data bit pass through matching two-flop pipelines. An edge is therefore acted on at the third rising clock edge after the pin changes, and the address and data seen at that moment are the ones that accompanied the strobe.

Top module: `dram_cycle_decoder`

## Requirements
- R1: After reset `evt_valid` is 0, `evt_kind` is 0, `q_oe` is 0, every array cell reads 0, and the internal refresh row counter is 0.
- R2: A strobe change on the pins shows up on `evt_*` and `q_oe` at the third rising clock edge after the change, and not earlier.
- R3: If CAS is low when RAS falls, the period is a column-first refresh. An event of kind 5 reports the refresh counter value as its row, and the address bus is ignored. The counter then advances by one and wraps to 0 after 2^ADDR_W refreshes.
- R4: If RAS falls with CAS high and rises again with no CAS fall in between, an event of kind 4 reports the row taken at the RAS fall. `q_oe` stays 0.
- R5: If W is low when CAS falls, the access is an early write. An event of kind 2 is raised at that CAS fall with the data bit present then, the bit is stored, and `q_oe` stays 0 for the whole access.
- R6: If W is high when CAS falls, the access is a read. `q_oe` becomes 1 and `q_out` shows the stored bit while CAS stays low. When CAS rises, `q_oe` returns to 0 and an event of kind 1 carries the bit that was read.
- R7: If W falls while CAS is low during a read access, the data bit present at that W fall is stored. The output keeps the read value until CAS rises, and the event at the CAS rise has kind 3 and carries the written bit.
- R8: The row is the address at the RAS fall. The column is the address at the CAS fall, and later address changes within the access have no effect.
- R9: Successive CAS falls within one RAS-low period each form their own access on the same row. The RAS rise that ends such a period raises no event.
- R10: `evt_valid` is a single-cycle pulse, and `evt_kind` is 0 whenever `evt_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ras_n | input | 1 | Row strobe, active low, asynchronous |
| cas_n | input | 1 | Column strobe, active low, asynchronous |
| we_n | input | 1 | Write enable, active low, asynchronous |
| addr | input | ADDR_W | Multiplexed row/column address |
| din | input | 1 | Data-in bit |
| q_out | output | 1 | Data-out bit, 0 while not enabled |
| q_oe | output | 1 | Data-out enable |
| evt_valid | output | 1 | One-cycle event strobe |
| evt_kind | output | 3 | 1 read, 2 early write, 3 late write, 4 row-only refresh, 5 column-first refresh, 0 none |
| evt_row | output | ADDR_W | Row of the event |
| evt_col | output | ADDR_W | Column of the event (0 for refreshes) |
| evt_data | output | 1 | Data bit read or written (0 for refreshes) |

## Verification
A pin change is visible on the outputs at the third rising edge after it. The bench drives every pin at a falling clock edge and samples results on the third falling edge after the change, once per change. For the read output, the check at the second falling edge confirms that `q_oe` is still low, and the check at the third confirms that it is high. Event pulses are checked on the cycle they appear and once more one cycle later to confirm that they have dropped. Strobe moves that must raise no event, such as the end of a paged or refresh period, are followed by the same three-edge wait and a check that `evt_valid` is 0.

// File: rtl/dcd_pkg.sv
package dcd_pkg;
  typedef enum logic [2:0] {
    EV_NONE     = 3'd0,
    EV_READ     = 3'd1,
    EV_EARLY_WR = 3'd2,
    EV_LATE_WR  = 3'd3,
    EV_ROW_REF  = 3'd4,
    EV_CBR_REF  = 3'd5
  } ev_kind_e;

  typedef enum logic [1:0] {
    AC_READ  = 2'd0,
    AC_EARLY = 2'd1,
    AC_LATE  = 2'd2
  } acc_kind_e;

  localparam int STB_RAS = 0;
  localparam int STB_CAS = 1;
  localparam int STB_WE  = 2;
  localparam int NUM_STB = 3;
endpackage

// File: rtl/sync_pipe.sv
module sync_pipe #(
  parameter int W = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1 <= RST_VAL;
      q      <= RST_VAL;
    end else begin
      stage1 <= d;
      q      <= stage1;
    end
  end
endmodule

// File: rtl/edge_tap.sv
module edge_tap #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] lvl,
  output logic [W-1:0] prev,
  output logic [W-1:0] fall,
  output logic [W-1:0] rise
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev <= '1;
    else        prev <= lvl;
  end

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign fall[i] = prev[i] & ~lvl[i];
    assign rise[i] = ~prev[i] & lvl[i];
  end
endmodule

// File: rtl/row_refresh_ctr.sv
module row_refresh_ctr #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         adv,
  output logic [W-1:0] row
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   row <= '0;
    else if (adv) row <= row + 1'b1;
  end
endmodule

// File: rtl/bit_store.sv
module bit_store #(
  parameter int IDX_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic             wr_bit,
  input  logic [IDX_W-1:0] rd_idx,
  output logic             rd_bit
);
  localparam int CELLS = 1 << IDX_W;
  logic [CELLS-1:0] cells;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cells <= '0;
    else if (wr_en) cells[wr_idx] <= wr_bit;
  end

  assign rd_bit = cells[rd_idx];
endmodule

// File: rtl/dram_cycle_decoder.sv
module dram_cycle_decoder
  import dcd_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ras_n,
  input  logic              cas_n,
  input  logic              we_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              din,
  output logic              q_out,
  output logic              q_oe,
  output logic              evt_valid,
  output logic [2:0]        evt_kind,
  output logic [ADDR_W-1:0] evt_row,
  output logic [ADDR_W-1:0] evt_col,
  output logic              evt_data
);
  localparam int IDX_W = 2 * ADDR_W;
  localparam int DW    = ADDR_W + 1;

  function automatic logic [IDX_W-1:0] cell_of(input logic [ADDR_W-1:0] r,
                                                input logic [ADDR_W-1:0] c);
    return {r, c};
  endfunction

  // synchronised strobes, address and data, same latency
  logic [NUM_STB-1:0] stb_s, stb_p, stb_fall, stb_rise;
  logic [DW-1:0]      dat_s;
  logic [ADDR_W-1:0]  addr_s;
  logic               din_s;

  sync_pipe #(.W(NUM_STB), .RST_VAL({NUM_STB{1'b1}})) u_stb_sync (
    .clk(clk), .rst_n(rst_n), .d({we_n, cas_n, ras_n}), .q(stb_s));
  sync_pipe #(.W(DW), .RST_VAL({DW{1'b0}})) u_dat_sync (
    .clk(clk), .rst_n(rst_n), .d({din, addr}), .q(dat_s));
  edge_tap #(.W(NUM_STB)) u_edges (
    .clk(clk), .rst_n(rst_n), .lvl(stb_s), .prev(stb_p),
    .fall(stb_fall), .rise(stb_rise));

  assign addr_s = dat_s[ADDR_W-1:0];
  assign din_s  = dat_s[ADDR_W];

  // named internal events
  logic ras_fall, ras_rise, cas_fall, cas_rise, we_fall;
  logic ras_act, cbr_mode, cas_seen, acc_act;
  acc_kind_e acc_kind;
  logic [ADDR_W-1:0] row_q, col_q, ref_row;
  logic acc_data;
  logic cbr_go, acc_go, early_go, read_go, late_go, close_go, ronly_go;

  assign ras_fall = stb_fall[STB_RAS];
  assign ras_rise = stb_rise[STB_RAS];
  assign cas_fall = stb_fall[STB_CAS];
  assign cas_rise = stb_rise[STB_CAS];
  assign we_fall  = stb_fall[STB_WE];

  assign cbr_go   = ras_fall & ~stb_s[STB_CAS];
  assign acc_go   = cas_fall & ras_act & ~cbr_mode & ~stb_s[STB_RAS];
  assign early_go = acc_go & ~stb_s[STB_WE];
  assign read_go  = acc_go & stb_s[STB_WE];
  assign late_go  = we_fall & acc_act & (acc_kind == AC_READ) & ~cas_rise;
  assign close_go = cas_rise & acc_act;
  assign ronly_go = ras_rise & ras_act & ~cbr_mode & ~cas_seen;

  row_refresh_ctr #(.W(ADDR_W)) u_ref (
    .clk(clk), .rst_n(rst_n), .adv(cbr_go), .row(ref_row));

  logic             wr_en, rd_bit, wr_bit;
  logic [IDX_W-1:0] wr_idx, rd_idx;

  always_comb begin
    wr_en  = early_go | late_go;
    wr_idx = early_go ? cell_of(row_q, addr_s) : cell_of(row_q, col_q);
    wr_bit = din_s;
    rd_idx = cell_of(row_q, addr_s);
  end

  bit_store #(.IDX_W(IDX_W)) u_store (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_bit(wr_bit), .rd_idx(rd_idx), .rd_bit(rd_bit));

  logic q_bit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ras_act   <= 1'b0;
      cbr_mode  <= 1'b0;
      cas_seen  <= 1'b0;
      acc_act   <= 1'b0;
      acc_kind  <= AC_READ;
      acc_data  <= 1'b0;
      row_q     <= '0;
      col_q     <= '0;
      q_oe      <= 1'b0;
      q_bit     <= 1'b0;
      evt_valid <= 1'b0;
      evt_kind  <= EV_NONE;
      evt_row   <= '0;
      evt_col   <= '0;
      evt_data  <= 1'b0;
    end else begin
      evt_valid <= 1'b0;
      evt_kind  <= EV_NONE;
      if (ras_fall) begin
        ras_act  <= 1'b1;
        cas_seen <= 1'b0;
        cbr_mode <= cbr_go;
        if (cbr_go) begin
          evt_valid <= 1'b1;
          evt_kind  <= EV_CBR_REF;
          evt_row   <= ref_row;
          evt_col   <= '0;
          evt_data  <= 1'b0;
        end else begin
          row_q <= addr_s;
        end
      end
      if (ras_rise) begin
        ras_act  <= 1'b0;
        cbr_mode <= 1'b0;
        if (ronly_go) begin
          evt_valid <= 1'b1;
          evt_kind  <= EV_ROW_REF;
          evt_row   <= row_q;
          evt_col   <= '0;
          evt_data  <= 1'b0;
        end
      end
      if (acc_go) begin
        col_q    <= addr_s;
        cas_seen <= 1'b1;
        acc_act  <= 1'b1;
        if (early_go) begin
          acc_kind  <= AC_EARLY;
          acc_data  <= din_s;
          evt_valid <= 1'b1;
          evt_kind  <= EV_EARLY_WR;
          evt_row   <= row_q;
          evt_col   <= addr_s;
          evt_data  <= din_s;
        end else begin
          acc_kind <= AC_READ;
          acc_data <= rd_bit;
          q_oe     <= 1'b1;
          q_bit    <= rd_bit;
        end
      end
      if (late_go) begin
        acc_kind <= AC_LATE;
        acc_data <= din_s;
      end
      if (close_go) begin
        acc_act <= 1'b0;
        q_oe    <= 1'b0;
        if (acc_kind != AC_EARLY) begin
          evt_valid <= 1'b1;
          evt_kind  <= (acc_kind == AC_LATE) ? EV_LATE_WR : EV_READ;
          evt_row   <= row_q;
          evt_col   <= col_q;
          evt_data  <= acc_data;
        end
      end
    end
  end

  assign q_out = q_oe & q_bit;

  // R6
  oe_needs_cas_chk: assert property (@(posedge clk) disable iff (!rst_n)
    q_oe |-> !stb_p[STB_CAS]);
  // R6
  oe_rise_from_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(q_oe) |-> $past(cas_fall));
  // R5
  early_wr_no_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_valid && evt_kind == EV_EARLY_WR) |-> !q_oe);
  // R10
  kind_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !evt_valid |-> (evt_kind == EV_NONE));
  // R10
  kind_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt_valid |-> (evt_kind != EV_NONE));
  // R3
  ref_row_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cbr_go |=> $stable(ref_row));
  // R4
  row_ref_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_valid && evt_kind == EV_ROW_REF) |-> !q_oe);
endmodule

// File: tb/dram_cycle_decoder_bench.sv
module dram_cycle_decoder_bench;
  localparam int AW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1, din = 1'b0;
  logic [AW-1:0] addr = '0;
  logic q_out, q_oe, evt_valid, evt_data;
  logic [2:0] evt_kind;
  logic [AW-1:0] evt_row, evt_col;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  dram_cycle_decoder #(.ADDR_W(AW)) u_dram_cycle_decoder (
    .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .addr(addr), .din(din), .q_out(q_out), .q_oe(q_oe),
    .evt_valid(evt_valid), .evt_kind(evt_kind), .evt_row(evt_row),
    .evt_col(evt_col), .evt_data(evt_data));

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk_evt(input string req, input int kind, input int row,
                         input int col, input int data);
    chk({req, " valid"}, evt_valid, 1);
    chk({req, " kind"}, evt_kind, kind);
    chk({req, " row"}, evt_row, row);
    chk({req, " col"}, evt_col, col);
    chk({req, " data"}, evt_data, data);
    wt(1);
    chk({req, " R10 pulse drop"}, evt_valid, 0);
    chk({req, " R10 idle kind"}, evt_kind, 0);
  endtask

  // one column access inside an open row; early write if wr
  task automatic col_access(input int col, input bit wr, input bit d,
                            input int row, input int exp_rd, input int jam);
    addr = col[AW-1:0]; we_n = ~wr; din = d;
    wt(1);
    cas_n = 1'b0;
    wt(1);
    if (jam >= 0) addr = jam[AW-1:0];
    wt(1);
    chk("R2 oe not early", q_oe, 0);
    wt(1);
    if (wr) begin
      chk_evt("R5 early write", 2, row, col, d);
      chk("R5 oe low", q_oe, 0);
    end else begin
      chk("R6 oe high", q_oe, 1);
      chk("R6 q value", q_out, exp_rd);
    end
    cas_n = 1'b1;
    wt(3);
    if (!wr) chk_evt("R6 read event R8", 1, row, col, exp_rd);
    else chk("R5 no close event", evt_valid, 0);
    chk("R6 oe released", q_oe, 0);
    we_n = 1'b1;
  endtask

  task automatic open_row(input int row);
    addr = row[AW-1:0]; ras_n = 1'b0;
    wt(3);
    chk("R8 no event at row open", evt_valid, 0);
  endtask

  task automatic close_row();
    ras_n = 1'b1;
    wt(3);
    chk("R9 no event at row close", evt_valid, 0);
    wt(2);
  endtask

  task automatic t_reset();
    chk("R1 evt_valid", evt_valid, 0);
    chk("R1 evt_kind", evt_kind, 0);
    chk("R1 q_oe", q_oe, 0);
  endtask

  task automatic t_write_read();
    open_row(3); col_access(5, 1'b1, 1'b1, 3, 0, -1); close_row();
    open_row(3); col_access(5, 1'b0, 1'b0, 3, 1, -1); close_row();
    // R1: untouched cell reads 0
    open_row(12); col_access(0, 1'b0, 1'b0, 12, 0, -1); close_row();
  endtask

  task automatic t_page();
    open_row(2);
    col_access(1, 1'b1, 1'b1, 2, 0, -1);
    col_access(7, 1'b1, 1'b0, 2, 0, -1);
    col_access(1, 1'b0, 1'b0, 2, 1, -1);
    // R8: column jammed after CAS fall has no effect
    col_access(7, 1'b0, 1'b0, 2, 0, 1);
    close_row();
    open_row(2); col_access(1, 1'b0, 1'b0, 2, 1, 15); close_row();
  endtask

  task automatic t_rmw();
    open_row(6);
    addr = 4'd9; we_n = 1'b1; din = 1'b0;
    wt(1);
    cas_n = 1'b0;
    wt(3);
    chk("R7 read phase oe", q_oe, 1);
    chk("R7 read phase q", q_out, 0);
    we_n = 1'b0; din = 1'b1;
    wt(1);
    din = 1'b0;
    wt(3);
    chk("R7 oe held", q_oe, 1);
    chk("R7 q held", q_out, 0);
    chk("R7 no event before CAS rise", evt_valid, 0);
    cas_n = 1'b1;
    wt(3);
    chk_evt("R7 late write", 3, 6, 9, 1);
    we_n = 1'b1;
    close_row();
    open_row(6); col_access(9, 1'b0, 1'b0, 6, 1, -1); close_row();
  endtask

  task automatic t_row_only();
    addr = 4'd10; ras_n = 1'b0;
    wt(3);
    chk("R4 no event on fall", evt_valid, 0);
    addr = 4'd3;
    wt(2);
    ras_n = 1'b1;
    wt(3);
    chk("R4 oe low", q_oe, 0);
    chk_evt("R4 row refresh", 4, 10, 0, 0);
    wt(2);
  endtask

  task automatic t_cbr();
    cas_n = 1'b0;
    wt(1);
    for (int i = 0; i <= 16; i++) begin
      addr = 4'd15; ras_n = 1'b0;
      wt(3);
      chk("R3 oe low", q_oe, 0);
      chk_evt("R3 R1 cbr row", 5, i % 16, 0, 0);
      ras_n = 1'b1;
      wt(3);
      chk("R3 no event on rise", evt_valid, 0);
    end
    cas_n = 1'b1;
    wt(3);
    chk("R3 no event after CAS rise", evt_valid, 0);
  endtask

  initial begin
    wt(4);
    rst_n = 1'b1;
    wt(2);
    t_reset();
    t_cbr();
    t_write_read();
    t_page();
    t_rmw();
    t_row_only();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule